// File: doc/BRIEF.md
# Pixel-Clock Sync and Enable Waveform Regenerator

This block rebuilds the vertical sync, horizontal sync and data-enable waveforms of one sub-image from counters that run on the pixel clock. It does not use line and column counters with porches. Each signal is described by a few durations measured in pixel clocks across the whole frame: a wait after frame start, a high time, a low time, a number of pulses, and a long low time that closes the sequence. A pulse on the frame-start input restarts all three generators at once. A status flag reports when a frame start arrived while any generator was still inside its sequence.

The settings are loaded through a single-cycle register write port. Typical values come from display timing. The horizontal sync has zero wait, a high time equal to the sync width, a low time equal to active plus both porches, and one pulse per total line. The data-enable waits back porch plus sync width, stays high for the active width, and pulses once per active line. The vertical sync waits total line length times (active lines plus front porch) and stays high for total line length times sync lines. The vertical sync emits a single pulse, and its low time serves as the closing low interval.

Top module: `frame_sync_regen`

## Requirements
- R1: While reset is asserted and after its release, `vs_out`, `hs_out`, `de_out` and `overrun` are low until the first frame start.
- R2: A write with `wr_en` high stores `wr_data` into the field picked by `wr_addr`: 0 VS wait, 1 VS high, 2 VS closing low, 3 HS wait, 4 HS high, 5 HS low, 6 HS pulse count, 7 HS closing low, 8 DE wait, 9 DE high, 10 DE low, 11 DE pulse count, 12 DE closing low. The HS and DE high, low and count fields keep only the lower 16 bits of `wr_data`. The other fields keep 24 bits. The write takes effect from the next clock.
- R3: If frame start is sampled at clock edge 0 and a signal's wait is D, the signal is first seen high after edge D. With D = 0, it is high right after edge 0.
- R4: The HS and DE outputs alternate high for the high time and low for the low time, and emit exactly the programmed number of high pulses.
- R5: After the final HS or DE pulse, the output stays low for the closing low time instead of the normal low time. It then stays low until the next frame start.
- R6: VS emits one high pulse of the VS high time after its wait. It then stays low.
- R7: A high time of zero keeps that output low for the whole frame.
- R8: A low time of zero merges consecutive pulses, so the output stays high for count times the high time.
- R9: A pulse count of zero produces no high pulse in the frame.
- R10: A frame start received mid-sequence abandons the running sequence. It restarts every generator from its wait.
- R11: At each frame start, `overrun` becomes 1 if any generator had not finished, and 0 otherwise. Between frame starts it holds its value.
- R12: A write to an address from 13 to 15 changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame start strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Field select |
| wr_data | input | 24 | Write data |
| vs_out | output | 1 | Regenerated vertical sync |
| hs_out | output | 1 | Regenerated horizontal sync |
| de_out | output | 1 | Regenerated data enable |
| overrun | output | 1 | Last frame start came before all sequences finished |

## Verification
Every result is due a fixed number of cycles after the edge at which frame start is sampled. Each output comes straight from a state register, so an output's expected value in cycle j after that edge depends only on the wait, high, low, count and closing-low settings. `overrun` changes at the frame-start edge itself and is valid from cycle 0. The driver pushes one expected item per cycle of each frame into a queue, numbered from the frame-start edge. The monitor pops one item per clock, sampling 2 ns after the rising edge, so every comparison lands on the cycle the requirement names. Register writes take effect one edge after they are sampled and are always completed before the frame that uses them.

// File: rtl/frame_sync_regen_pkg.sv
package frame_sync_regen_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_VS_WAIT = 4'd0,
        SEL_VS_ON   = 4'd1,
        SEL_VS_TAIL = 4'd2,
        SEL_HS_WAIT = 4'd3,
        SEL_HS_ON   = 4'd4,
        SEL_HS_OFF  = 4'd5,
        SEL_HS_NUM  = 4'd6,
        SEL_HS_TAIL = 4'd7,
        SEL_DE_WAIT = 4'd8,
        SEL_DE_ON   = 4'd9,
        SEL_DE_OFF  = 4'd10,
        SEL_DE_NUM  = 4'd11,
        SEL_DE_TAIL = 4'd12
    } field_sel_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_HIGH,
        PH_LOW,
        PH_TAIL
    } phase_e;

endpackage

// File: rtl/frame_sync_cfg.sv
module frame_sync_cfg
    import frame_sync_regen_pkg::*;
#(
    parameter int LW = 24,
    parameter int SW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [LW-1:0]    wr_data,
    output logic [LW-1:0]    vs_wait,
    output logic [LW-1:0]    vs_on,
    output logic [LW-1:0]    vs_tail,
    output logic [LW-1:0]    hs_wait,
    output logic [SW-1:0]    hs_on,
    output logic [SW-1:0]    hs_off,
    output logic [SW-1:0]    hs_num,
    output logic [LW-1:0]    hs_tail,
    output logic [LW-1:0]    de_wait,
    output logic [SW-1:0]    de_on,
    output logic [SW-1:0]    de_off,
    output logic [SW-1:0]    de_num,
    output logic [LW-1:0]    de_tail
);

    typedef struct packed {
        logic [LW-1:0] vs_wait;
        logic [LW-1:0] vs_on;
        logic [LW-1:0] vs_tail;
        logic [LW-1:0] hs_wait;
        logic [SW-1:0] hs_on;
        logic [SW-1:0] hs_off;
        logic [SW-1:0] hs_num;
        logic [LW-1:0] hs_tail;
        logic [LW-1:0] de_wait;
        logic [SW-1:0] de_on;
        logic [SW-1:0] de_off;
        logic [SW-1:0] de_num;
        logic [LW-1:0] de_tail;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [SW-1:0] narrow;

    assign narrow = wr_data[SW-1:0];

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (field_sel_e'(wr_addr))
                SEL_VS_WAIT: bank_d.vs_wait = wr_data;
                SEL_VS_ON:   bank_d.vs_on   = wr_data;
                SEL_VS_TAIL: bank_d.vs_tail = wr_data;
                SEL_HS_WAIT: bank_d.hs_wait = wr_data;
                SEL_HS_ON:   bank_d.hs_on   = narrow;
                SEL_HS_OFF:  bank_d.hs_off  = narrow;
                SEL_HS_NUM:  bank_d.hs_num  = narrow;
                SEL_HS_TAIL: bank_d.hs_tail = wr_data;
                SEL_DE_WAIT: bank_d.de_wait = wr_data;
                SEL_DE_ON:   bank_d.de_on   = narrow;
                SEL_DE_OFF:  bank_d.de_off  = narrow;
                SEL_DE_NUM:  bank_d.de_num  = narrow;
                SEL_DE_TAIL: bank_d.de_tail = wr_data;
                default:     bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign vs_wait = bank_q.vs_wait;
    assign vs_on   = bank_q.vs_on;
    assign vs_tail = bank_q.vs_tail;
    assign hs_wait = bank_q.hs_wait;
    assign hs_on   = bank_q.hs_on;
    assign hs_off  = bank_q.hs_off;
    assign hs_num  = bank_q.hs_num;
    assign hs_tail = bank_q.hs_tail;
    assign de_wait = bank_q.de_wait;
    assign de_on   = bank_q.de_on;
    assign de_off  = bank_q.de_off;
    assign de_num  = bank_q.de_num;
    assign de_tail = bank_q.de_tail;

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
    import frame_sync_regen_pkg::*;
#(
    parameter int WAIT_W = 24,
    parameter int ON_W   = 16,
    parameter int OFF_W  = 16,
    parameter int NUM_W  = 16,
    parameter int TAIL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [WAIT_W-1:0] wait_len,
    input  logic [ON_W-1:0]   on_len,
    input  logic [OFF_W-1:0]  off_len,
    input  logic [NUM_W-1:0]  num_pulses,
    input  logic [TAIL_W-1:0] tail_len,
    output logic              wave,
    output logic              busy
);

    localparam int M1 = (WAIT_W > ON_W) ? WAIT_W : ON_W;
    localparam int M2 = (OFF_W > TAIL_W) ? OFF_W : TAIL_W;
    localparam int TW = (M1 > M2) ? M1 : M2;

    typedef struct packed {
        phase_e           ph;
        logic [TW-1:0]    tmr;
        logic [NUM_W-1:0] left;
    } gen_t;

    gen_t gen_d, gen_q;
    gen_t train, after_on, closing, reload_on;

    always_comb begin
        // Closing low interval, or idle when it is zero
        closing = '{ph: PH_IDLE, tmr: '0, left: '0};
        if (tail_len != '0) closing = '{ph: PH_TAIL, tmr: TW'(tail_len), left: '0};

        // Start of the pulse train after the wait
        if (num_pulses == '0)   train = closing;
        else if (on_len == '0)  train = '{ph: PH_IDLE, tmr: '0, left: '0};
        else                    train = '{ph: PH_HIGH, tmr: TW'(on_len), left: num_pulses};

        // End of a high phase: count down, then low, next high or closing
        if (gen_q.left <= NUM_W'(1))  after_on = closing;
        else if (off_len != '0)       after_on = '{ph: PH_LOW, tmr: TW'(off_len),
                                                   left: gen_q.left - NUM_W'(1)};
        else                          after_on = '{ph: PH_HIGH, tmr: TW'(on_len),
                                                   left: gen_q.left - NUM_W'(1)};

        // End of a low phase
        if (on_len == '0) reload_on = '{ph: PH_IDLE, tmr: '0, left: '0};
        else              reload_on = '{ph: PH_HIGH, tmr: TW'(on_len), left: gen_q.left};

        gen_d = gen_q;
        if (restart) begin
            if (wait_len != '0) gen_d = '{ph: PH_WAIT, tmr: TW'(wait_len), left: '0};
            else                gen_d = train;
        end else begin
            case (gen_q.ph)
                PH_WAIT: if (gen_q.tmr == TW'(1)) gen_d = train;
                         else gen_d.tmr = gen_q.tmr - TW'(1);
                PH_HIGH: if (gen_q.tmr == TW'(1)) gen_d = after_on;
                         else gen_d.tmr = gen_q.tmr - TW'(1);
                PH_LOW:  if (gen_q.tmr == TW'(1)) gen_d = reload_on;
                         else gen_d.tmr = gen_q.tmr - TW'(1);
                PH_TAIL: if (gen_q.tmr == TW'(1)) gen_d = '{ph: PH_IDLE, tmr: '0, left: '0};
                         else gen_d.tmr = gen_q.tmr - TW'(1);
                default: gen_d = gen_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '{ph: PH_IDLE, tmr: '0, left: '0};
        else        gen_q <= gen_d;
    end

    assign wave = (gen_q.ph == PH_HIGH);
    assign busy = (gen_q.ph != PH_IDLE);

endmodule

// File: rtl/frame_sync_regen.sv
module frame_sync_regen
    import frame_sync_regen_pkg::*;
#(
    parameter int LONG_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [LONG_W-1:0] wr_data,
    output logic              vs_out,
    output logic              hs_out,
    output logic              de_out,
    output logic              overrun
);

    localparam int NGEN = 3;

    logic [LONG_W-1:0]  vs_wait_q, vs_on_q, vs_tail_q, hs_wait_q, hs_tail_q, de_wait_q, de_tail_q;
    logic [SHORT_W-1:0] hs_on_q, hs_off_q, hs_num_q, de_on_q, de_off_q, de_num_q;
    logic [NGEN-1:0]    busy_vec;

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t top_d, top_q;

    frame_sync_cfg #(.LW(LONG_W), .SW(SHORT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vs_wait(vs_wait_q), .vs_on(vs_on_q), .vs_tail(vs_tail_q),
        .hs_wait(hs_wait_q), .hs_on(hs_on_q), .hs_off(hs_off_q), .hs_num(hs_num_q), .hs_tail(hs_tail_q),
        .de_wait(de_wait_q), .de_on(de_on_q), .de_off(de_off_q), .de_num(de_num_q), .de_tail(de_tail_q)
    );

    // Vertical sync: one pulse, its low time is the closing interval
    frame_pulse_gen #(.WAIT_W(LONG_W), .ON_W(LONG_W), .OFF_W(1), .NUM_W(1), .TAIL_W(LONG_W)) vs_gen_i (
        .clk(clk), .rst_n(rst_n), .restart(frame_start),
        .wait_len(vs_wait_q), .on_len(vs_on_q), .off_len(1'b0), .num_pulses(1'b1),
        .tail_len(vs_tail_q), .wave(vs_out), .busy(busy_vec[0])
    );

    frame_pulse_gen #(.WAIT_W(LONG_W), .ON_W(SHORT_W), .OFF_W(SHORT_W), .NUM_W(SHORT_W), .TAIL_W(LONG_W)) hs_gen_i (
        .clk(clk), .rst_n(rst_n), .restart(frame_start),
        .wait_len(hs_wait_q), .on_len(hs_on_q), .off_len(hs_off_q), .num_pulses(hs_num_q),
        .tail_len(hs_tail_q), .wave(hs_out), .busy(busy_vec[1])
    );

    frame_pulse_gen #(.WAIT_W(LONG_W), .ON_W(SHORT_W), .OFF_W(SHORT_W), .NUM_W(SHORT_W), .TAIL_W(LONG_W)) de_gen_i (
        .clk(clk), .rst_n(rst_n), .restart(frame_start),
        .wait_len(de_wait_q), .on_len(de_on_q), .off_len(de_off_q), .num_pulses(de_num_q),
        .tail_len(de_tail_q), .wave(de_out), .busy(busy_vec[2])
    );

    always_comb begin
        top_d = top_q;
        if (frame_start) top_d.ovr = |busy_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign overrun = top_q.ovr;

endmodule

// File: rtl/frame_sync_regen_chk.sv
module frame_sync_regen_chk #(
    parameter int LW = 24,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          vs_out,
    input logic          hs_out,
    input logic          de_out,
    input logic          overrun,
    input logic [LW-1:0] vs_wait,
    input logic [LW-1:0] vs_on,
    input logic [LW-1:0] hs_wait,
    input logic [SW-1:0] hs_on,
    input logic [SW-1:0] de_on
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!vs_out && !hs_out && !de_out && !overrun));

    p_vs_zero_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && vs_wait == '0 && vs_on != '0) |=> vs_out);

    p_hs_zero_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && hs_wait == '0 && hs_on != '0) |=> hs_out);

    p_hs_zero_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on == '0 && !hs_out) |=> !hs_out);

    p_de_zero_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de_on == '0 && !de_out) |=> !de_out);

    p_overrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (vs_out || hs_out || de_out)) |=> overrun);

    p_overrun_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(overrun));

endmodule

bind frame_sync_regen frame_sync_regen_chk #(.LW(LONG_W), .SW(SHORT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .vs_out(vs_out), .hs_out(hs_out), .de_out(de_out), .overrun(overrun),
    .vs_wait(vs_wait_q), .vs_on(vs_on_q), .hs_wait(hs_wait_q),
    .hs_on(hs_on_q), .de_on(de_on_q)
);

// File: tb/frame_sync_regen_tb_top.sv
`timescale 1ns/1ps
module frame_sync_regen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        vs_out, hs_out, de_out, overrun;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0] expv;   // {vs, hs, de, overrun}
        string      tag;
        int         idx;
    } item_t;

    item_t exp_q[$];

    // Shadow settings, as the requirements define them
    int vs_w, vs_h, vs_t;
    int hs_w, hs_h, hs_l, hs_n, hs_t;
    int de_w, de_h, de_l, de_n, de_t;

    always #2.5 clk = ~clk;

    frame_sync_regen dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vs_out(vs_out), .hs_out(hs_out), .de_out(de_out), .overrun(overrun)
    );

    // Expected level in cycle j after the frame-start edge
    function automatic logic level_at(int j, int w, int h, int l, int n, int t);
        int k;
        if (h == 0 || j < w) return 1'b0;
        k = j - w;
        for (int p = 0; p < n; p++) begin
            if (k < h) return 1'b1;
            k -= h;
            if (p < n - 1) begin
                if (k < l) return 1'b0;
                k -= l;
            end
        end
        return 1'b0;
    endfunction

    task automatic wr(input int addr, input int data);
        @(posedge clk); #3;
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 24'(data);
        @(posedge clk); #3;
        wr_en = 1'b0;
    endtask

    task automatic load_all();
        wr(0, vs_w); wr(1, vs_h); wr(2, vs_t);
        wr(3, hs_w); wr(4, hs_h); wr(5, hs_l); wr(6, hs_n); wr(7, hs_t);
        wr(8, de_w); wr(9, de_h); wr(10, de_l); wr(11, de_n); wr(12, de_t);
    endtask

    // Starts a frame and queues n cycles of expected outputs; the next frame starts at edge n
    task automatic run_frame(input int n, input logic ovr, input string tag);
        item_t it;
        for (int j = 0; j < n; j++) begin
            it.expv = {level_at(j, vs_w, vs_h, 0, 1, vs_t),
                       level_at(j, hs_w, hs_h, hs_l, hs_n, hs_t),
                       level_at(j, de_w, de_h, de_l, de_n, de_t),
                       ovr};
            it.tag = tag;
            it.idx = j;
            exp_q.push_back(it);
        end
        frame_start = 1'b1;
        repeat (n) begin
            @(posedge clk); #3;
            frame_start = 1'b0;
        end
    endtask

    // Monitor: compares one queued item per clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            item_t it;
            logic [3:0] got;
            it = exp_q.pop_front();
            got = {vs_out, hs_out, de_out, overrun};
            applied++;
            if (got !== it.expv) begin
                miscompares++;
                $display("FAIL %s cycle %0d: vs/hs/de/ovr got %b expected %b",
                         it.tag, it.idx, got, it.expv);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: quiet while in reset and after release
        repeat (3) @(posedge clk);
        #3;
        applied++;
        if ({vs_out, hs_out, de_out, overrun} !== 4'b0) begin
            miscompares++;
            $display("FAIL R1 in reset: got %b expected 0000", {vs_out, hs_out, de_out, overrun});
        end
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #3;
        applied++;
        if ({vs_out, hs_out, de_out, overrun} !== 4'b0) begin
            miscompares++;
            $display("FAIL R1 after release: got %b expected 0000", {vs_out, hs_out, de_out, overrun});
        end

        // R2 R3 R4 R5 R6: general frame
        vs_w = 3; vs_h = 4; vs_t = 2;
        hs_w = 0; hs_h = 2; hs_l = 3; hs_n = 3; hs_t = 4;
        de_w = 1; de_h = 3; de_l = 2; de_n = 2; de_t = 1;
        load_all();
        run_frame(20, 1'b0, "R3/R4/R5/R6");
        // R10 R11: cut a frame short, then a full one, then a clean one
        run_frame(8, 1'b0, "R10 cut");
        run_frame(20, 1'b1, "R10/R11 restart with overrun");
        run_frame(20, 1'b0, "R11 clean start");

        // R2 truncation (high field takes low 16 bits -> 2), R8 zero low, R7 zero high, R3 zero wait
        vs_w = 0; vs_h = 1; vs_t = 0;
        hs_h = 2; hs_l = 0; hs_n = 3; hs_t = 2;
        de_w = 1; de_h = 0; de_l = 2; de_n = 2;
        wr(0, 0); wr(1, 1); wr(2, 0);
        wr(4, 24'hAB0002); wr(5, 0); wr(7, 2);
        wr(8, 1); wr(9, 0);
        run_frame(14, 1'b0, "R2/R3/R7/R8");

        // R9: zero count, with a non-zero HS wait
        hs_w = 5;
        de_h = 3; de_n = 0; de_t = 2;
        wr(3, 5); wr(9, 3); wr(11, 0); wr(12, 2);
        run_frame(16, 1'b0, "R9");

        // R12: writes to unmapped addresses leave every field unchanged
        wr(13, 24'hFFFFFF); wr(14, 0); wr(15, 24'h000001);
        run_frame(16, 1'b0, "R12");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule